// File: doc/BRIEF.md
# Coded Programmable Clock Divider

This block turns a fast source clock into a slower output clock whose ratio is chosen by a 7-bit code. The code table is not linear. The three lowest codes all mean divide-by-two. The next three codes give the ratios three, four and five. For every code from six upward, the lowest code bit is ignored and the ratio is twice the upper six bits, so the even ratios run from 6 to 126.

Every ratio, odd ones included, gives a high time equal to half the period, measured in half-cycles of the source clock. Odd ratios get this by combining a phase stepped on the rising edge with a copy of that phase retimed on the falling edge.

A new code is taken only at the end of a period, so the output never shows a shortened pulse. A disable input pulls the true output low and the complement output high at once. When the disable is released, counting restarts from the beginning of a fresh period. The clock feeding the block can be a loop oscillator or, in bypass operation, the reference itself; the block behaves the same either way.

Top module: `coded_clk_div`

## Requirements
- R1: Codes 0, 1 and 2 each give a period of 2 source cycles.
- R2: Codes 3, 4 and 5 give periods of 3, 4 and 5 source cycles respectively.
- R3: For a code c of 6 or more, the period is 2*(c>>1) source cycles, so bit 0 of the code has no effect on the output.
- R4: For an even ratio R, the output rises at the rising edge that opens a period, stays high for R/2 cycles and low for R/2 cycles.
- R5: For an odd ratio R, the output rises on the falling edge half a cycle after the period opens and stays high for R half-cycles, then low for R half-cycles, until the next period opens.
- R6: After reset or after the disable is released, the first period opens at the first rising edge that samples the disable low, and it uses the code present at that edge.
- R7: A code change during a period does not alter that period. The new ratio starts with the next period.
- R8: While the disable input is 1, q_o is 0 and qn_o is 1. This takes effect in the same time step, with no clock edge needed.
- R9: qn_o is always the complement of q_o.
- R10: While reset is asserted, q_o is 0 and qn_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 7 | Coded division ratio |
| dis_i | input | 1 | 1 forces the output to its off state |
| q_o | output | 1 | Divided clock, true polarity |
| qn_o | output | 1 | Divided clock, complement |

## Verification
Every one of the 128 codes is applied from a disabled start. The output is sampled at both half-cycle points over three full periods. This separates the three regions of the code table, tests that bit 0 is ignored, and checks the two duty-cycle schemes for even and odd ratios.

Code changes are made at the first cycle, in the middle and on the terminal cycle of a period, across odd-to-even and even-to-odd pairs. These runs tell a change taken at the boundary apart from one taken early. The disable is also raised in the middle of a high phase, which shows whether the output drops at once or only at the next edge.

// File: rtl/coded_clk_div.sv
`timescale 1ns/1ps
module coded_clk_div #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] code_i,
  input  logic          dis_i,
  output logic          q_o,
  output logic          qn_o
);

  logic [CW-1:0] ratio_dec, div_q, cnt_q, div_nxt, cnt_nxt, half_w;
  logic          pos_q, neg_q, pos_nxt, term, core;

  always_comb begin
    if (code_i < CW'(3))      ratio_dec = CW'(2);
    else if (code_i < CW'(6)) ratio_dec = code_i;
    else                      ratio_dec = {code_i[CW-1:1], 1'b0};
  end

  assign term   = (cnt_q == div_q - 1'b1);
  assign half_w = (div_q + 1'b1) >> 1;

  always_comb begin
    if (dis_i) begin
      div_nxt = ratio_dec;
      cnt_nxt = ratio_dec - 1'b1;
      pos_nxt = 1'b0;
    end else if (term) begin
      div_nxt = ratio_dec;
      cnt_nxt = '0;
      pos_nxt = 1'b1;
    end else begin
      div_nxt = div_q;
      cnt_nxt = cnt_q + 1'b1;
      pos_nxt = (cnt_q + 1'b1) < half_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= CW'(2);
      cnt_q <= CW'(1);
      pos_q <= 1'b0;
    end else begin
      div_q <= div_nxt;
      cnt_q <= cnt_nxt;
      pos_q <= pos_nxt;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= pos_q;
  end

  assign core = div_q[0] ? (pos_q & neg_q) : pos_q;
  assign q_o  = core & ~dis_i;
  assign qn_o = ~q_o;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_q); // R4
  AST_DIV_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q >= CW'(2)) && (!div_q[0] || div_q == CW'(3) || div_q == CW'(5))); // R3
  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!term && !dis_i) |=> $stable(div_q)); // R7
  AST_RISE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_q) |-> (cnt_q == '0)); // R6

endmodule

// File: tb/coded_clk_div_bench.sv
`timescale 1ns/1ps
module coded_clk_div_bench;
  logic clk = 1'b0, rst_n = 1'b0, dis = 1'b0;
  logic [6:0] code = '0;
  logic q, qn;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  coded_clk_div u_coded_clk_div (.clk_i(clk), .rst_ni(rst_n), .code_i(code),
                                 .dis_i(dis), .q_o(q), .qn_o(qn));

  always #5 clk = ~clk;

  function automatic int ratio_of(input int c);
    if (c <= 2) return 2;
    if (c <= 5) return c;
    return (c / 2) * 2;
  endfunction

  function automatic bit expv(input int r, input int j);
    if (r % 2 == 1) return (j >= 1) && (j <= r);
    return j < r;
  endfunction

  task automatic chk(input bit e, input string tag);
    vectors++;
    if (q !== e || qn !== ~e) begin
      miscompares++;
      $display("FAIL %s t=%0t code=%0d q=%b qn=%b expected q=%b qn=%b",
               tag, $time, code, q, qn, e, ~e);
    end
  endtask

  task automatic run(input int ca, input int cb, input int chg, input string tag);
    int ra, rb, r;
    @(posedge clk); #1 dis = 1'b1; code = 7'(ca);
    @(posedge clk); #1.5 chk(1'b0, "R8");
    @(posedge clk); #1 dis = 1'b0;
    ra = ratio_of(ca);
    rb = (chg >= 0) ? ratio_of(cb) : ra;
    for (int p = 0; p < 3; p++) begin
      r = (p == 0) ? ra : rb;
      for (int c = 0; c < r; c++) begin
        @(posedge clk); #1;
        if (p == 0 && c == chg) code = 7'(cb);
        #1.5 chk(expv(r, 2 * c), tag);
        #5 chk(expv(r, 2 * c + 1), tag);
      end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #2 chk(1'b0, "R10");
    @(posedge clk); #2 chk(1'b0, "R10");
    @(posedge clk); #7 chk(1'b0, "R10 R9");
    #1 rst_n = 1'b1;
    // R1 R2 R3 R4 R5 R6: every code from a disabled start
    for (int c = 0; c < 128; c++)
      run(c, 0, -1, (c <= 2) ? "R1" : (c <= 5) ? "R2 R5" : "R3 R4");
    // R7: code changes inside a period
    run(8, 3, 2, "R7");
    run(3, 10, 0, "R7");
    run(5, 2, 4, "R7");
    run(126, 4, 60, "R7");
    run(2, 5, 1, "R7");
    run(7, 6, 2, "R7 R3");
    // R8: disable during a high phase acts at once
    run(16, 0, -1, "R4");
    @(posedge clk); #3 chk(1'b1, "R4");
    dis = 1'b1;
    #0.1 chk(1'b0, "R8");
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #2.5 chk(1'b0, "R8");
      #5 chk(1'b0, "R8 R9");
    end
    run(4, 0, -1, "R6");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule